// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block chooses where each of the two ALU operands of a five-stage in-order pipeline comes from while an instruction sits in the execute stage. An operand can come from the value read out of the register file, from the ALU result of the instruction one step ahead, or from the value of the instruction two steps ahead. The value two steps ahead is the load data for a load and the ALU result otherwise. The choice is made by comparing the executing instruction's two source register numbers with the destination number and write flag of the two older in-flight instructions.

For testing, the selection logic is wrapped in a small tracking harness. One instruction enters execute each cycle. The operand multiplexers feed an adder, and the adder's sum is carried into the two older stage registers, so that dependent chains forward real values. The selects, the chosen operands and the sum are registered at the clock edge that ends the instruction's execute cycle. They are visible one cycle after the instruction is presented. The reset is synchronous and active high.

Top module: `opfwd_unit`

## Requirements
- R1: Each select output uses a 2-bit code: 2'b00 takes the register-file value, 2'b10 takes the result held one stage ahead, 2'b01 takes the value held two stages ahead. The code 2'b11 never appears.
- R2: An operand select is 2'b10 when the stage one ahead writes a register, its destination is nonzero, and its destination equals that operand's source number. Operand A uses `in_rs` and operand B uses `in_rt`.
- R3: An operand select is 2'b01 when the stage two ahead writes a nonzero destination equal to the source number, and the destination number of the stage one ahead differs from that source. A match one ahead blocks this even when that newer instruction does not write. As a result, in a chain that accumulates into one register, the newer result always wins.
- R4: An instruction presented with `in_wen` low, or with `in_vld` low (a bubble), is never forwarded from, even when register numbers match.
- R5: A source number of zero is never forwarded.
- R6: When neither R2 nor R3 applies, the select is 2'b00 and the operand equals the register-file value presented with the instruction.
- R7: A forwarded operand equals the producer's ALU sum (one stage ahead), or, two stages ahead, the `mem_rdata` sampled while a load producer was one stage ahead, or the producer's sum for a non-load.
- R8: `sel_a`, `sel_b`, `opnd_a`, `opnd_b` and `alu_res` = `opnd_a + opnd_b` (modulo 2^DATA_W) appear one cycle after the instruction is presented.
- R9: A synchronous reset clears all outputs to zero and empties both older stages, so that the first instructions after reset read the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Instruction present in execute (low = bubble) |
| in_rs | input | REG_W | Source register number for operand A |
| in_rt | input | REG_W | Source register number for operand B |
| in_rd | input | REG_W | Destination register number |
| in_wen | input | 1 | Instruction writes its destination |
| in_ld | input | 1 | Instruction is a load (value two ahead comes from memory) |
| in_rf_a | input | DATA_W | Register-file value for operand A |
| in_rf_b | input | DATA_W | Register-file value for operand B |
| mem_rdata | input | DATA_W | Load data for the instruction one stage ahead |
| sel_a | output | 2 | Registered select for operand A |
| sel_b | output | 2 | Registered select for operand B |
| opnd_a | output | DATA_W | Registered chosen operand A |
| opnd_b | output | DATA_W | Registered chosen operand B |
| alu_res | output | DATA_W | Registered sum of the chosen operands |

## Verification
Both the one-ahead and the two-ahead comparisons can hit in the same cycle. They can hit on one operand, where the priority rule must pick the newer stage. They can also hit on different operands, where A and B must resolve independently. Directed sequences provoke each case: an accumulate chain into r1, a non-writing one-ahead instruction that shares the source number, and two producers feeding rs and rt. Random streams over a four-register pool then make such overlaps frequent. Every select and operand is judged against a bench shadow of the two older stages.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF = 2'b00,
    SRC_MW = 2'b01,
    SRC_EM = 2'b10
  } fwd_src_e;

  localparam int unsigned N_OPND = 2;
endpackage

// File: rtl/opfwd_pick.sv
module opfwd_pick #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0]      src,
  input  logic [REG_W-1:0]      em_rd,
  input  logic                  em_wen,
  input  logic [REG_W-1:0]      mw_rd,
  input  logic                  mw_wen,
  output opfwd_pkg::fwd_src_e   sel
);
  import opfwd_pkg::*;

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic em_hit;
  logic em_same;
  logic mw_hit;

  always_comb begin
    em_same = (em_rd == src);
    em_hit  = em_wen && (em_rd != ZERO_REG) && em_same;
    mw_hit  = mw_wen && (mw_rd != ZERO_REG) && (mw_rd == src) && !em_same;
    if (em_hit)      sel = SRC_EM;
    else if (mw_hit) sel = SRC_MW;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  opfwd_pkg::fwd_src_e sel,
  input  logic [DATA_W-1:0]   rf_val,
  input  logic [DATA_W-1:0]   em_val,
  input  logic [DATA_W-1:0]   mw_val,
  output logic [DATA_W-1:0]   out_val
);
  import opfwd_pkg::*;

  always_comb begin
    unique case (sel)
      SRC_EM:  out_val = em_val;
      SRC_MW:  out_val = mw_val;
      default: out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/opfwd_track.sv
module opfwd_track #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [REG_W-1:0]  in_rd,
  input  logic              in_wen,
  input  logic              in_ld,
  input  logic [DATA_W-1:0] in_res,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [REG_W-1:0]  em_rd,
  output logic              em_wen,
  output logic [DATA_W-1:0] em_val,
  output logic [REG_W-1:0]  mw_rd,
  output logic              mw_wen,
  output logic [DATA_W-1:0] mw_val
);
  logic em_ld;

  // Stage one ahead: the instruction leaving execute
  always_ff @(posedge clk) begin
    if (rst) begin
      em_rd  <= '0;
      em_wen <= 1'b0;
      em_ld  <= 1'b0;
      em_val <= '0;
    end else begin
      em_rd  <= in_vld ? in_rd : '0;
      em_wen <= in_vld & in_wen;
      em_ld  <= in_vld & in_ld;
      em_val <= in_res;
    end
  end

  // Stage two ahead: memory data replaces the sum for loads
  always_ff @(posedge clk) begin
    if (rst) begin
      mw_rd  <= '0;
      mw_wen <= 1'b0;
      mw_val <= '0;
    end else begin
      mw_rd  <= em_rd;
      mw_wen <= em_wen;
      mw_val <= em_ld ? mem_rdata : em_val;
    end
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [REG_W-1:0]  in_rs,
  input  logic [REG_W-1:0]  in_rt,
  input  logic [REG_W-1:0]  in_rd,
  input  logic              in_wen,
  input  logic              in_ld,
  input  logic [DATA_W-1:0] in_rf_a,
  input  logic [DATA_W-1:0] in_rf_b,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] alu_res
);
  import opfwd_pkg::*;

  logic [REG_W-1:0]  em_rd;
  logic              em_wen;
  logic [DATA_W-1:0] em_val;
  logic [REG_W-1:0]  mw_rd;
  logic              mw_wen;
  logic [DATA_W-1:0] mw_val;

  logic [REG_W-1:0]  src_num [N_OPND];
  logic [DATA_W-1:0] rf_val  [N_OPND];
  fwd_src_e          sel     [N_OPND];
  logic [DATA_W-1:0] opnd    [N_OPND];
  logic [DATA_W-1:0] sum;

  assign src_num[0] = in_rs;
  assign src_num[1] = in_rt;
  assign rf_val[0]  = in_rf_a;
  assign rf_val[1]  = in_rf_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
    opfwd_pick #(.REG_W(REG_W)) u_pick (
      .src    (src_num[gi]),
      .em_rd  (em_rd),
      .em_wen (em_wen),
      .mw_rd  (mw_rd),
      .mw_wen (mw_wen),
      .sel    (sel[gi])
    );
    opfwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel[gi]),
      .rf_val  (rf_val[gi]),
      .em_val  (em_val),
      .mw_val  (mw_val),
      .out_val (opnd[gi])
    );
  end

  assign sum = opnd[0] + opnd[1];

  opfwd_track #(.REG_W(REG_W), .DATA_W(DATA_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_rd     (in_rd),
    .in_wen    (in_wen),
    .in_ld     (in_ld),
    .in_res    (sum),
    .mem_rdata (mem_rdata),
    .em_rd     (em_rd),
    .em_wen    (em_wen),
    .em_val    (em_val),
    .mw_rd     (mw_rd),
    .mw_wen    (mw_wen),
    .mw_val    (mw_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a   <= SRC_RF;
      sel_b   <= SRC_RF;
      opnd_a  <= '0;
      opnd_b  <= '0;
      alu_res <= '0;
    end else begin
      sel_a   <= sel[0];
      sel_b   <= sel[1];
      opnd_a  <= opnd[0];
      opnd_b  <= opnd[1];
      alu_res <= sum;
    end
  end
endmodule

// File: rtl/opfwd_chk.sv
module opfwd_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  in_rs,
  input logic [REG_W-1:0]  in_rt,
  input logic [REG_W-1:0]  em_rd,
  input logic              em_wen,
  input logic [DATA_W-1:0] em_val,
  input logic [REG_W-1:0]  mw_rd,
  input logic              mw_wen,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a
);
  a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  a_r2_near_hit_a: assert property (@(posedge clk) disable iff (rst)
    (em_wen && em_rd != '0 && em_rd == in_rs) |=> (sel_a == 2'b10));

  a_r3_far_hit_b: assert property (@(posedge clk) disable iff (rst)
    (mw_wen && mw_rd != '0 && mw_rd == in_rt && em_rd != in_rt) |=> (sel_b == 2'b01));

  a_r4_idle_stages: assert property (@(posedge clk) disable iff (rst)
    (!em_wen && !mw_wen) |=> (sel_a == 2'b00 && sel_b == 2'b00));

  a_r5_zero_src: assert property (@(posedge clk) disable iff (rst)
    (in_rs == '0) |=> (sel_a == 2'b00));

  a_r7_near_value: assert property (@(posedge clk) disable iff (rst)
    (em_wen && em_rd != '0 && em_rd == in_rs) |=> (opnd_a == $past(em_val)));
endmodule

bind opfwd_unit opfwd_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .in_rs  (in_rs),
  .in_rt  (in_rt),
  .em_rd  (em_rd),
  .em_wen (em_wen),
  .em_val (em_val),
  .mw_rd  (mw_rd),
  .mw_wen (mw_wen),
  .sel_a  (sel_a),
  .sel_b  (sel_b),
  .opnd_a (opnd_a)
);

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;
  localparam int unsigned RW = 5;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [RW-1:0] in_rs = '0, in_rt = '0, in_rd = '0;
  logic          in_wen = 1'b0, in_ld = 1'b0;
  logic [DW-1:0] in_rf_a = '0, in_rf_b = '0, mem_rdata = '0;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, alu_res;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // shadow of the two older stages
  logic [RW-1:0] s_em_rd = '0, s_mw_rd = '0;
  logic          s_em_wen = 1'b0, s_em_ld = 1'b0, s_mw_wen = 1'b0;
  logic [DW-1:0] s_em_val = '0, s_mw_val = '0;

  always #4 clk = ~clk;

  opfwd_unit #(.REG_W(RW), .DATA_W(DW)) u_opfwd_unit (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rs(in_rs), .in_rt(in_rt),
    .in_rd(in_rd), .in_wen(in_wen), .in_ld(in_ld), .in_rf_a(in_rf_a),
    .in_rf_b(in_rf_b), .mem_rdata(mem_rdata), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res)
  );

  function automatic logic [1:0] exp_sel(input logic [RW-1:0] s);
    if (s_em_wen && s_em_rd != 0 && s_em_rd == s) return 2'b10;
    if (s_mw_wen && s_mw_rd != 0 && s_mw_rd == s && s_em_rd != s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] exp_val(input logic [1:0] sl, input logic [DW-1:0] rf);
    if (sl == 2'b10) return s_em_val;
    if (sl == 2'b01) return s_mw_val;
    return rf;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [RW-1:0] rs,
                      input logic [RW-1:0] rt, input logic [RW-1:0] rd,
                      input logic w, input logic l, input logic [DW-1:0] mdat);
    logic [1:0]    esa, esb;
    logic [DW-1:0] ea, eb, rfa, rfb;
    rfa = $urandom;
    rfb = $urandom;
    @(negedge clk);
    in_vld = v; in_rs = rs; in_rt = rt; in_rd = rd; in_wen = w; in_ld = l;
    in_rf_a = rfa; in_rf_b = rfb; mem_rdata = mdat;
    esa = exp_sel(rs);
    esb = exp_sel(rt);
    ea  = exp_val(esa, rfa);
    eb  = exp_val(esb, rfb);
    @(posedge clk);
    #2;
    chk({tag, " R1 sel_a"}, {30'd0, sel_a}, {30'd0, esa});
    chk({tag, " R1 sel_b"}, {30'd0, sel_b}, {30'd0, esb});
    chk({tag, " R7 opnd_a"}, opnd_a, ea);
    chk({tag, " R7 opnd_b"}, opnd_b, eb);
    chk({tag, " R8 alu_res"}, alu_res, ea + eb);
    s_mw_rd  = s_em_rd;
    s_mw_wen = s_em_wen;
    s_mw_val = s_em_ld ? mdat : s_em_val;
    s_em_rd  = v ? rd : '0;
    s_em_wen = v & w;
    s_em_ld  = v & l;
    s_em_val = ea + eb;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0f0d));
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset sel_a", {30'd0, sel_a}, 0);
    chk("R9 reset alu_res", alu_res, 0);
    @(negedge clk);
    rst = 1'b0;

    // R9: stages empty right after reset
    step("R9 first", 1, 5'd3, 5'd4, 5'd3, 1, 0, 0);

    // R3 priority: accumulate chain into r1
    step("R3 acc0", 1, 5'd1, 5'd2, 5'd1, 1, 0, 0);
    step("R3 acc1", 1, 5'd1, 5'd2, 5'd1, 1, 0, 0);
    step("R3 acc2", 1, 5'd1, 5'd2, 5'd1, 1, 0, 0);

    // R5: zero destination never forwarded
    step("R5 prod", 1, 5'd9, 5'd9, 5'd0, 1, 0, 0);
    step("R5 use", 1, 5'd0, 5'd0, 5'd11, 1, 0, 0);

    // R4: non-writing producer, and bubble
    step("R4 nowr", 1, 5'd12, 5'd13, 5'd5, 0, 0, 0);
    step("R4 use", 1, 5'd5, 5'd5, 5'd14, 1, 0, 0);
    step("R4 bubble", 0, 5'd12, 5'd13, 5'd3, 1, 0, 0);
    step("R4 fill", 1, 5'd15, 5'd16, 5'd17, 1, 0, 0);
    step("R4 use2", 1, 5'd3, 5'd3, 5'd18, 1, 0, 0);

    // R7: load data arrives through the two-ahead path
    step("R7 load", 1, 5'd20, 5'd21, 5'd7, 1, 1, 0);
    step("R7 gap", 1, 5'd22, 5'd23, 5'd9, 1, 0, 32'hCAFE_0123);
    step("R7 use", 1, 5'd7, 5'd24, 5'd25, 1, 0, 0);

    // R3: non-writing match one ahead blocks two-ahead
    step("R3 old", 1, 5'd26, 5'd27, 5'd6, 1, 0, 0);
    step("R3 blk", 1, 5'd28, 5'd29, 5'd6, 0, 0, 0);
    step("R3 use", 1, 5'd6, 5'd6, 5'd30, 1, 0, 0);

    // R2 and R3 on different operands in one cycle
    step("R2 p8", 1, 5'd1, 5'd2, 5'd8, 1, 0, 0);
    step("R2 p10", 1, 5'd3, 5'd4, 5'd10, 1, 0, 0);
    step("R2 mix", 1, 5'd10, 5'd8, 5'd31, 1, 0, 0);

    // R6: no matches at all
    step("R6 none", 1, 5'd19, 5'd18, 5'd2, 1, 0, 0);

    // random chains over a small register pool
    for (int i = 0; i < 400; i++) begin
      step("R2 rnd", ($urandom % 8) != 0, RW'($urandom % 4), RW'($urandom % 4),
           RW'($urandom % 4), ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule